// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

The block buffers 9-bit words between a write clock domain and an unrelated read clock domain. Writes and reads are requested with active-low enables. Four active-low status outputs report the fill level. Empty and almost-empty are produced in the read domain. Full and almost-full are produced in the write domain. Both pointers cross the clock boundary as Gray code through two-flop synchronizers. The flags therefore lag the true level by a few cycles, always in the safe direction.

The two almost-flag thresholds are held in offset registers, each settable to any single word count. While the load strobe is low, write-clock writes load these registers and read-clock reads return their contents. The load strobe also acts as a mode strap that is sampled during reset. Low selects standalone mode, which enables offset access and the retransmit input. Retransmit rewinds the read side to the first word stored since reset. High selects a cascade-ready mode, in which the strobe and retransmit are ignored. An output-enable input produces a valid qualifier for the data output in place of a three-state driver.

Top module: `dcfifo_progflags`

## Requirements
- R1: While rst_ni is low, empty_no and aempty_no are low, full_no and afull_no are high, and rdata_o is zero. Enables are ignored during reset.
- R2: A write takes place on a rising wclk_i edge when wen_ni is low and full_no is high. A read takes place on a rising rclk_i edge when ren_ni is low and empty_no is high, and loads the oldest word into rdata_o. Words leave in the order they were written. rdata_o changes only on a read edge.
- R3: After DEPTH stored words, full_no goes low and further writes are discarded.
- R4: While empty_no is low, read requests are ignored and rdata_o keeps the last word read.
- R5: aempty_no is low when the number of stored words is at or below the almost-empty offset. That offset is 7 after reset. empty_no low implies aempty_no low.
- R6: afull_no is low when the number of free locations is at or below the almost-full offset. That offset is 7 after reset. full_no low implies afull_no low.
- R7: In standalone mode, a write with ld_ni low stores wdata_i[AW-1:0] into an offset register instead of the FIFO. Successive loads alternate almost-empty first, then almost-full. Raising ld_ni returns the sequence to almost-empty.
- R8: In standalone mode, a read with ld_ni low places an offset in rdata_o, zero-extended, in the same alternating order as R7. The FIFO read pointer is left untouched.
- R9: In standalone mode, an rclk_i edge with rt_ni low returns the read pointer to the first location. Later reads repeat the words from the first one written since reset. This holds while fewer than DEPTH words have been written since reset.
- R10: If ld_ni is high while reset is asserted, the block runs in cascade-ready mode. In that mode ld_ni and rt_ni have no effect, writes and reads always act on the FIFO, and the offsets stay at their reset values.
- R11: rdata_vld_o is high exactly when oe_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Offset access strobe and reset-time mode strap, active low |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | DW | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rt_ni | input | 1 | Retransmit strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| rdata_o | output | DW | Registered read data |
| rdata_vld_o | output | 1 | Output data qualifier |
| empty_no | output | 1 | Empty flag, active low, read domain |
| aempty_no | output | 1 | Almost-empty flag, active low, read domain |
| full_no | output | 1 | Full flag, active low, write domain |
| afull_no | output | 1 | Almost-full flag, active low, write domain |

## Verification
The bench builds the block with DEPTH set to 16 and the data width left at 9. With that depth, the fill-to-full and overrun cases take only a few dozen writes. The almost-full boundary at seven free words falls in the middle of the array. The 4-bit address also wraps during the drain tests. The two clocks share a 250 MHz period but are offset by a quarter of it, so every flag crosses a real synchronizer boundary before it is sampled.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } off_sel_e;

  function automatic off_sel_e sel_next(off_sel_e s);
    return (s == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction
endpackage

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcfifo_gsync.sv
module dcfifo_gsync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr
  import dcfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int AE_RST = 7,
  parameter int AF_RST = 7,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          wen_ni,
  input  logic [AW-1:0] off_din_i,
  input  logic [AW:0]   rptr_bin_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_no,
  output logic          afull_no,
  output logic [AW-1:0] ae_off_o,
  output logic [AW-1:0] af_off_o
);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic          sa_q;
  logic [AW:0]   wptr_q, wptr_nxt, gray_q, cnt_nxt, free_nxt;
  logic          full_nq, afull_nq;
  logic [AW-1:0] ae_q, af_q;
  off_sel_e      sel_q;
  logic          load_wr, do_wr;

  // mode strap, sampled on clock edges while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) sa_q <= ~ld_ni;
  end

  assign load_wr  = sa_q & ~ld_ni & ~wen_ni;
  assign do_wr    = ~wen_ni & full_nq & ~(sa_q & ~ld_ni);
  assign wptr_nxt = wptr_q + (AW+1)'(do_wr);
  assign cnt_nxt  = wptr_nxt - rptr_bin_i;
  assign free_nxt = DEPTH_W - cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      gray_q   <= '0;
      full_nq  <= 1'b1;
      afull_nq <= 1'b1;
    end else begin
      wptr_q   <= wptr_nxt;
      gray_q   <= wptr_nxt ^ (wptr_nxt >> 1);
      full_nq  <= (cnt_nxt != DEPTH_W);
      afull_nq <= !(free_nxt <= {1'b0, af_q});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q  <= AW'(AE_RST);
      af_q  <= AW'(AF_RST);
      sel_q <= SEL_AE;
    end else if (ld_ni) begin
      sel_q <= SEL_AE;
    end else if (load_wr) begin
      if (sel_q == SEL_AE) ae_q <= off_din_i;
      else                 af_q <= off_din_i;
      sel_q <= sel_next(sel_q);
    end
  end

  assign we_o     = do_wr;
  assign waddr_o  = wptr_q[AW-1:0];
  assign wptr_o   = wptr_q;
  assign wgray_o  = gray_q;
  assign full_no  = full_nq;
  assign afull_no = afull_nq;
  assign ae_off_o = ae_q;
  assign af_off_o = af_q;
endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd
  import dcfifo_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          ren_ni,
  input  logic          rt_ni,
  input  logic [AW:0]   wptr_bin_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rptr_o,
  output logic [AW:0]   rgray_o,
  output logic          sa_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no,
  output logic          aempty_no
);
  logic          sa_q;
  logic [AW:0]   rptr_q, rptr_nxt, gray_q, cnt_nxt;
  logic          empty_nq, aempty_nq;
  logic [DW-1:0] rdata_q;
  off_sel_e      sel_q;
  logic          rt_act, ld_act, do_rd, ld_rd;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sa_q <= ~ld_ni;
  end

  assign rt_act   = sa_q & ~rt_ni;
  assign ld_act   = sa_q & ~ld_ni;
  assign do_rd    = ~ren_ni & empty_nq & ~ld_act & ~rt_act;
  assign ld_rd    = ~ren_ni & ld_act & ~rt_act;
  assign rptr_nxt = rt_act ? '0 : rptr_q + (AW+1)'(do_rd);
  assign cnt_nxt  = wptr_bin_i - rptr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q    <= '0;
      gray_q    <= '0;
      empty_nq  <= 1'b0;
      aempty_nq <= 1'b0;
    end else begin
      rptr_q    <= rptr_nxt;
      gray_q    <= rptr_nxt ^ (rptr_nxt >> 1);
      empty_nq  <= (cnt_nxt != '0);
      aempty_nq <= !(cnt_nxt <= {1'b0, ae_off_i});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      sel_q   <= SEL_AE;
    end else begin
      if (do_rd) begin
        rdata_q <= mem_rdata_i;
      end else if (ld_rd) begin
        rdata_q <= (sel_q == SEL_AE) ? DW'(ae_off_i) : DW'(af_off_i);
      end
      if (ld_ni)      sel_q <= SEL_AE;
      else if (ld_rd) sel_q <= sel_next(sel_q);
    end
  end

  assign raddr_o   = rptr_q[AW-1:0];
  assign rptr_o    = rptr_q;
  assign rgray_o   = gray_q;
  assign sa_o      = sa_q;
  assign rdata_o   = rdata_q;
  assign empty_no  = empty_nq;
  assign aempty_no = aempty_nq;
endmodule

// File: rtl/dcfifo_progflags.sv
module dcfifo_progflags #(
  parameter int DW     = 9,
  parameter int DEPTH  = 64,
  parameter int AE_RST = 7,
  parameter int AF_RST = 7
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          wen_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_ni,
  input  logic          rt_ni,
  input  logic          oe_ni,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_vld_o,
  output logic          empty_no,
  output logic          aempty_no,
  output logic          full_no,
  output logic          afull_no
);
  localparam int AW = $clog2(DEPTH);

  initial begin
    if ((1 << AW) != DEPTH || AW > DW || AW < 2)
      $error("DEPTH must be a power of two between 4 and 2**DW");
  end

  logic          we_w;
  logic [AW-1:0] waddr_w, raddr_r, ae_off, af_off;
  logic [AW:0]   wptr_w, wgray_w, rptr_r, rgray_r, rptr_sync_w, wptr_sync_r;
  logic [DW-1:0] mem_rdata;
  logic          sa_r;

  dcfifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we_w),
    .waddr_i(waddr_w),
    .wdata_i(wdata_i),
    .raddr_i(raddr_r),
    .rdata_o(mem_rdata)
  );

  dcfifo_wr #(.DEPTH(DEPTH), .AE_RST(AE_RST), .AF_RST(AF_RST)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .ld_ni     (ld_ni),
    .wen_ni    (wen_ni),
    .off_din_i (wdata_i[AW-1:0]),
    .rptr_bin_i(rptr_sync_w),
    .we_o      (we_w),
    .waddr_o   (waddr_w),
    .wptr_o    (wptr_w),
    .wgray_o   (wgray_w),
    .full_no   (full_no),
    .afull_no  (afull_no),
    .ae_off_o  (ae_off),
    .af_off_o  (af_off)
  );

  dcfifo_rd #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rst_ni),
    .ld_ni      (ld_ni),
    .ren_ni     (ren_ni),
    .rt_ni      (rt_ni),
    .wptr_bin_i (wptr_sync_r),
    .ae_off_i   (ae_off),
    .af_off_i   (af_off),
    .mem_rdata_i(mem_rdata),
    .raddr_o    (raddr_r),
    .rptr_o     (rptr_r),
    .rgray_o    (rgray_r),
    .sa_o       (sa_r),
    .rdata_o    (rdata_o),
    .empty_no   (empty_no),
    .aempty_no  (aempty_no)
  );

  dcfifo_gsync #(.W(AW+1)) u_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rgray_r),
    .bin_o (rptr_sync_w)
  );

  dcfifo_gsync #(.W(AW+1)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wgray_w),
    .bin_o (wptr_sync_r)
  );

  assign rdata_vld_o = ~oe_ni;
endmodule

// File: rtl/dcfifo_progflags_chk.sv
module dcfifo_progflags_chk #(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          ld_ni,
  input logic          wen_ni,
  input logic          ren_ni,
  input logic          rt_ni,
  input logic [DW-1:0] rdata_o,
  input logic          empty_no,
  input logic          aempty_no,
  input logic          full_no,
  input logic          afull_no,
  input logic [AW:0]   wptr_w,
  input logic [AW:0]   rptr_r,
  input logic          sa_r
);
  // R2
  wr_advance_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wen_ni && full_no && ld_ni) |=> (wptr_w == $past(wptr_w) + 1'b1));

  // R2
  rdata_idle_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ren_ni |=> $stable(rdata_o));

  // R3
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wptr_w));

  // R4
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && ld_ni && rt_ni) |=> ($stable(rdata_o) && $stable(rptr_r)));

  // R5
  empty_implies_ae_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);

  // R6
  full_implies_af_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);

  // R9
  retransmit_rewind_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rt_ni && sa_r) |=> (rptr_r == '0));
endmodule

bind dcfifo_progflags dcfifo_progflags_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .ld_ni    (ld_ni),
  .wen_ni   (wen_ni),
  .ren_ni   (ren_ni),
  .rt_ni    (rt_ni),
  .rdata_o  (rdata_o),
  .empty_no (empty_no),
  .aempty_no(aempty_no),
  .full_no  (full_no),
  .afull_no (afull_no),
  .wptr_w   (wptr_w),
  .rptr_r   (rptr_r),
  .sa_r     (sa_r)
);

// File: tb/dcfifo_progflags_tb.sv
module dcfifo_progflags_tb;
  localparam int DW = 9;
  localparam int DEPTH = 16;

  logic wclk_i = 1'b0, rclk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ld_ni = 1'b0, wen_ni = 1'b1, ren_ni = 1'b1, rt_ni = 1'b1, oe_ni = 1'b1;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic rdata_vld_o, empty_no, aempty_no, full_no, afull_no;
  int n_chk = 0, n_err = 0;

  always #2 wclk_i = ~wclk_i;
  initial begin
    #1;
    forever #2 rclk_i = ~rclk_i;
  end

  dcfifo_progflags #(.DW(DW), .DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic do_reset(input logic strap);
    rst_ni = 1'b0; ld_ni = strap; wen_ni = 1'b1; ren_ni = 1'b1; rt_ni = 1'b1;
    repeat (4) @(negedge wclk_i);
    rst_ni = 1'b1;
    ld_ni  = 1'b1;
    repeat (2) @(negedge wclk_i);
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk_i);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk_i);
    wen_ni = 1'b0; wdata_i = d;
    @(negedge wclk_i);
    wen_ni = 1'b1;
  endtask

  task automatic pop(output logic [DW-1:0] d);
    @(negedge rclk_i);
    ren_ni = 1'b0;
    @(negedge rclk_i);
    ren_ni = 1'b1;
    d = rdata_o;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; ld_ni = 1'b0;
    repeat (4) @(negedge wclk_i);
    chk("R1 empty", empty_no, 0);
    chk("R1 aempty", aempty_no, 0);
    chk("R1 full", full_no, 1);
    chk("R1 afull", afull_no, 1);
    chk("R1 rdata", rdata_o, 0);
    do_reset(1'b0);
  endtask

  task automatic t_order();
    logic [DW-1:0] d;
    for (int i = 0; i < 5; i++) push(DW'(9'h020 + i));
    settle();
    chk("R5 aempty at 5", aempty_no, 0);
    chk("R2 not empty", empty_no, 1);
    for (int i = 5; i < 8; i++) push(DW'(9'h020 + i));
    settle();
    chk("R5 aempty at 8", aempty_no, 1);
    chk("R6 afull at 8 free", afull_no, 1);
    for (int i = 0; i < 8; i++) begin
      pop(d);
      chk("R2 order", d, DW'(9'h020 + i));
    end
    settle();
    chk("R4 empty", empty_no, 0);
    pop(d);
    chk("R4 hold last", d, 9'h027);
  endtask

  task automatic t_full();
    logic [DW-1:0] d;
    do_reset(1'b0);
    chk("R1 rdata cleared", rdata_o, 0);
    for (int i = 0; i < 8; i++) push(DW'(9'h140 + i));
    settle();
    chk("R6 afull 8 free", afull_no, 1);
    push(9'h148);
    settle();
    chk("R6 afull 7 free", afull_no, 0);
    chk("R3 not full", full_no, 1);
    for (int i = 9; i < DEPTH; i++) push(DW'(9'h140 + i));
    settle();
    chk("R3 full", full_no, 0);
    push(9'h1FF);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      chk("R3 drain", d, DW'(9'h140 + i));
    end
    settle();
    chk("R3 overrun dropped", empty_no, 0);
    chk("R3 full released", full_no, 1);
  endtask

  task automatic t_offsets();
    logic [DW-1:0] d;
    do_reset(1'b0);
    @(negedge wclk_i); ld_ni = 1'b0;
    push(9'h003);
    push(9'h00C);
    @(negedge wclk_i); ld_ni = 1'b1;
    @(negedge wclk_i); ld_ni = 1'b0;
    push(9'h002);
    @(negedge wclk_i); ld_ni = 1'b1;
    settle();
    chk("R7 loads not stored", empty_no, 0);
    push(9'h0A0); push(9'h0A1);
    settle();
    chk("R7 aempty 2 words", aempty_no, 0);
    push(9'h0A2);
    settle();
    chk("R7 aempty 3 words", aempty_no, 1);
    chk("R7 afull 13 free", afull_no, 1);
    push(9'h0A3);
    settle();
    chk("R7 afull 12 free", afull_no, 0);
    @(negedge rclk_i); ld_ni = 1'b0;
    pop(d);
    chk("R8 readback ae", d, 9'h002);
    pop(d);
    chk("R8 readback af", d, 9'h00C);
    @(negedge rclk_i); ld_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      pop(d);
      chk("R8 pointer kept", d, DW'(9'h0A0 + i));
    end
  endtask

  task automatic t_retransmit();
    logic [DW-1:0] d;
    do_reset(1'b0);
    for (int i = 0; i < 4; i++) push(DW'(9'h0B0 + i));
    settle();
    pop(d); pop(d);
    chk("R9 pre", d, 9'h0B1);
    @(negedge rclk_i); rt_ni = 1'b0;
    @(negedge rclk_i); rt_ni = 1'b1;
    settle();
    for (int i = 0; i < 4; i++) begin
      pop(d);
      chk("R9 replay", d, DW'(9'h0B0 + i));
    end
    settle();
    chk("R9 empty after replay", empty_no, 0);
  endtask

  task automatic t_strap();
    logic [DW-1:0] d;
    do_reset(1'b1);
    @(negedge wclk_i); ld_ni = 1'b0;
    push(9'h0C0); push(9'h0C1);
    settle();
    chk("R10 writes stored", empty_no, 1);
    chk("R10 offsets default", aempty_no, 0);
    pop(d);
    chk("R10 read is data", d, 9'h0C0);
    @(negedge rclk_i); rt_ni = 1'b0;
    @(negedge rclk_i); rt_ni = 1'b1;
    pop(d);
    chk("R10 rt ignored", d, 9'h0C1);
    @(negedge rclk_i); ld_ni = 1'b1;
    settle();
    chk("R10 drained", empty_no, 0);
  endtask

  task automatic t_oe();
    @(negedge rclk_i); oe_ni = 1'b0;
    #1 chk("R11 vld on", rdata_vld_o, 1);
    oe_ni = 1'b1;
    #1 chk("R11 vld off", rdata_vld_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge wclk_i);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    t_reset();
    t_order();
    t_full();
    t_offsets();
    t_retransmit();
    t_strap();
    t_oe();
    summary();
  end
endmodule